// File: doc/BRIEF.md
# Sample Phase Tuning Engine

This block picks the receive sample phase for a memory-card host interface. On a start request it walks a 3-bit phase select through all eight phases. At each phase it first loads the transfer timeout with its maximum value. It then asks an external command engine for one tuning transfer through a request/acknowledge handshake. The single pass/fail bit returned with each acknowledge is collected into an 8-bit candidate mask.

When the walk is done, a ranked search over the circular mask chooses the phase. It first looks for a centre phase whose two neighbours on each side also passed. Failing that, it looks for a centre with one passing neighbour on each side. As a last resort it takes the lowest passing phase. The chosen phase drives the sample-phase select and is kept as the tuned value. If nothing passed, an error is flagged and the phase is left untouched. Done pulses once at the end. The delay line, the card protocol and the data compare stay outside the block.

Top module: `sample_phase_tuner`

## Requirements
- R1: `startReq` is acted on only while the engine is idle; a start pulse during a sweep changes neither the number nor the order of the transfers.
- R2: The first tuning transfer of a sweep is made at (P+1) mod 8, where P is the phase on `phaseSel` when the sweep started. Each later transfer is made at the previous phase plus one, modulo 8.
- R3: Before every tuning transfer, `tmoLoad` pulses for one cycle, and `tmoValue` is all ones.
- R4: A sweep makes exactly eight transfers, the last one at phase P. `xferReq` stays high until the cycle in which `xferAck` is seen.
- R5: An acknowledged transfer at phase s sets bit s of `candMask` when `xferPass` is 1 and `xferTimeout` is 0, and clears it otherwise. A timeout counts as a fail.
- R6: The first search tier picks the lowest phase c for which phases c-2, c-1, c, c+1 and c+2 (mod 8) all passed.
- R7: If R6 finds nothing, the lowest c for which phases c-1, c and c+1 (mod 8) passed is picked.
- R8: If R7 finds nothing, the lowest passing phase is picked.
- R9: With an all-zero mask, `error` is 1 and both `phaseSel` and `tunedPhase` keep their values.
- R10: On success, `phaseSel` and `tunedPhase` both equal the picked phase when `done` is high. `done` is high for exactly one cycle, and `error` is valid in that cycle.
- R11: After reset, `phaseSel` and `tunedPhase` are 0, and `done`, `error` and `xferReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a sweep (taken only when idle) |
| xferReq | output | 1 | Tuning transfer request, held until acknowledged |
| xferAck | input | 1 | Transfer finished, status valid |
| xferPass | input | 1 | Transfer passed (valid with xferAck) |
| xferTimeout | input | 1 | Transfer timed out (valid with xferAck) |
| tmoLoad | output | 1 | Load the transfer timeout before a transfer |
| tmoValue | output | 24 | Timeout value to load (all ones) |
| phaseSel | output | 3 | Sample-phase select to the delay line |
| tunedPhase | output | 3 | Last successfully tuned phase |
| candMask | output | 8 | Pass mask of the current or last sweep |
| done | output | 1 | One-cycle end-of-sweep pulse |
| error | output | 1 | No phase passed in the last sweep |

## Verification
The embedded assertions watch several properties on every cycle:
- each step advances the phase by exactly one;
- each acknowledged status lands in the mask bit of the phase then selected;
- a request never drops before its acknowledge and always follows a timeout load;
- done never lasts two cycles;
- an empty-mask commit leaves both phase registers alone.

Whether the search ranks windows correctly can only be shown by the bench's scenarios. It sweeps all 256 pass patterns, plus timeout patterns, and compares the result with a reference search written with modular arithmetic. The bench also checks that the start phase is honoured across back-to-back sweeps and that a start pulse in mid-sweep is ignored.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_PICK = 2'd3
  } sweepState_t;

  typedef struct packed {
    logic sweepBegin;
    logic stepPhase;
    logic recordResult;
    logic commitPick;
  } sweepStrobe_t;

endpackage

// File: rtl/spt_datapath.sv
module spt_datapath #(
  parameter int PH_W        = 3,
  parameter int TMO_W       = 24,
  parameter int RESET_PHASE = 0,
  localparam int NPH        = 1 << PH_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  spt_pkg::sweepStrobe_t    stb,
  input  logic                     xferPass,
  input  logic                     xferTimeout,
  output logic                     atStart,
  output logic [PH_W-1:0]          phaseSel,
  output logic [PH_W-1:0]          tunedPhase,
  output logic [NPH-1:0]           candMask,
  output logic                     errFlag,
  output logic [TMO_W-1:0]         tmoValue
);

  logic [PH_W-1:0] startPhase;
  logic [PH_W-1:0] idxWide, idxNarrow, idxSingle, pickIdx;
  logic            hitWide, hitNarrow, hitSingle, anyPass;
  logic [NPH-1:0]  rot;

  assign tmoValue = '1;
  assign atStart  = (phaseSel == startPhase);
  assign anyPass  = |candMask;

  // Ranked window search over the circular mask, lowest centre wins.
  always_comb begin
    hitWide = 1'b0; hitNarrow = 1'b0; hitSingle = 1'b0;
    idxWide = '0;   idxNarrow = '0;   idxSingle = '0;
    rot = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      rot = (candMask >> i) | (candMask << (NPH - i));
      if (rot[0] && rot[1] && rot[2] && rot[NPH-1] && rot[NPH-2]) begin
        hitWide = 1'b1; idxWide = PH_W'(i);
      end
      if (rot[0] && rot[1] && rot[NPH-1]) begin
        hitNarrow = 1'b1; idxNarrow = PH_W'(i);
      end
      if (rot[0]) begin
        hitSingle = 1'b1; idxSingle = PH_W'(i);
      end
    end
    pickIdx = hitWide ? idxWide : (hitNarrow ? idxNarrow : idxSingle);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseSel   <= PH_W'(RESET_PHASE);
      tunedPhase <= PH_W'(RESET_PHASE);
      startPhase <= '0;
      candMask   <= '0;
      errFlag    <= 1'b0;
    end else begin
      if (stb.sweepBegin) begin
        startPhase <= phaseSel;
        candMask   <= '0;
        errFlag    <= 1'b0;
      end
      if (stb.sweepBegin || stb.stepPhase)
        phaseSel <= phaseSel + 1'b1;
      if (stb.recordResult)
        candMask[phaseSel] <= xferPass & ~xferTimeout;
      if (stb.commitPick) begin
        errFlag <= ~anyPass;
        if (anyPass && hitSingle) begin
          phaseSel   <= pickIdx;
          tunedPhase <= pickIdx;
        end
      end
    end
  end

  // R2: every advance moves the phase by exactly one, modulo the phase count
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sweepBegin || stb.stepPhase) |=> phaseSel == PH_W'($past(phaseSel) + 1'b1));

  // R5: status lands in the bit of the phase that was selected
  a_r5_record_bit: assert property (@(posedge clk) disable iff (!rstN)
    stb.recordResult |=> candMask[$past(phaseSel)] == $past(xferPass && !xferTimeout));

  // R9: an empty mask leaves both phase registers untouched
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitPick && candMask == '0) |=>
      (phaseSel == $past(phaseSel) && tunedPhase == $past(tunedPhase) && errFlag));

  // R10: a successful commit makes selected and tuned phase agree
  a_r10_commit_match: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitPick && candMask != '0) |=> (phaseSel == tunedPhase && !errFlag));

endmodule

// File: rtl/spt_control.sv
module spt_control (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startReq,
  input  logic                    xferAck,
  input  logic                    atStart,
  output spt_pkg::sweepStrobe_t   stb,
  output logic                    xferReq,
  output logic                    tmoLoad,
  output logic                    done
);
  import spt_pkg::*;

  sweepState_t state, nextState;

  assign xferReq = (state == ST_WAIT);
  assign tmoLoad = (state == ST_LOAD);

  always_comb begin
    stb.sweepBegin   = (state == ST_IDLE) && startReq;
    stb.recordResult = (state == ST_WAIT) && xferAck;
    stb.stepPhase    = (state == ST_WAIT) && xferAck && !atStart;
    stb.commitPick   = (state == ST_PICK);
    nextState = state;
    unique case (state)
      ST_IDLE: if (startReq) nextState = ST_LOAD;
      ST_LOAD: nextState = ST_WAIT;
      ST_WAIT: if (xferAck) nextState = atStart ? ST_PICK : ST_LOAD;
      ST_PICK: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_PICK);
    end
  end

  // R10: done never lasts more than one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: each request is preceded by a timeout load
  a_r3_load_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferReq) |-> $past(tmoLoad));

  // R4: an outstanding request is held until acknowledged
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferAck) |=> xferReq);

  // R1: a start seen mid-sweep does not restart the timeout load
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferAck && startReq) |=> !tmoLoad);

endmodule

// File: rtl/sample_phase_tuner.sv
module sample_phase_tuner #(
  parameter int PH_W        = 3,
  parameter int TMO_W       = 24,
  parameter int RESET_PHASE = 0,
  localparam int NPH        = 1 << PH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              xferReq,
  input  logic              xferAck,
  input  logic              xferPass,
  input  logic              xferTimeout,
  output logic              tmoLoad,
  output logic [TMO_W-1:0]  tmoValue,
  output logic [PH_W-1:0]   phaseSel,
  output logic [PH_W-1:0]   tunedPhase,
  output logic [NPH-1:0]    candMask,
  output logic              done,
  output logic              error
);

  spt_pkg::sweepStrobe_t stb;
  logic atStart;

  spt_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .xferAck  (xferAck),
    .atStart  (atStart),
    .stb      (stb),
    .xferReq  (xferReq),
    .tmoLoad  (tmoLoad),
    .done     (done)
  );

  spt_datapath #(
    .PH_W        (PH_W),
    .TMO_W       (TMO_W),
    .RESET_PHASE (RESET_PHASE)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .xferPass    (xferPass),
    .xferTimeout (xferTimeout),
    .atStart     (atStart),
    .phaseSel    (phaseSel),
    .tunedPhase  (tunedPhase),
    .candMask    (candMask),
    .errFlag     (error),
    .tmoValue    (tmoValue)
  );

endmodule

// File: tb/tb_sample_phase_tuner.sv
module tb_sample_phase_tuner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        xferAck = 1'b0;
  logic        xferPass = 1'b0;
  logic        xferTimeout = 1'b0;
  logic        xferReq, tmoLoad, done, error;
  logic [23:0] tmoValue;
  logic [2:0]  phaseSel, tunedPhase;
  logic [7:0]  candMask;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sample_phase_tuner dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .xferReq(xferReq),
    .xferAck(xferAck), .xferPass(xferPass), .xferTimeout(xferTimeout),
    .tmoLoad(tmoLoad), .tmoValue(tmoValue), .phaseSel(phaseSel),
    .tunedPhase(tunedPhase), .candMask(candMask), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference search built from R6..R8 with modular arithmetic
  function automatic int refPick(input bit [7:0] m);
    for (int c = 0; c < 8; c++) begin
      bit ok = 1'b1;
      for (int d = -2; d <= 2; d++) if (!m[(c + d + 8) % 8]) ok = 1'b0;
      if (ok) return c;                                   // R6
    end
    for (int c = 0; c < 8; c++)
      if (m[(c + 7) % 8] && m[c] && m[(c + 1) % 8]) return c; // R7
    for (int c = 0; c < 8; c++) if (m[c]) return c;         // R8
    return -1;
  endfunction

  task automatic sweep(input bit [7:0] passM, input bit [7:0] tmoM, input bit midStart);
    int startP, n, lat, exp;
    bit tmoSeen;
    bit [7:0] eff;
    int prevTuned;
    eff = passM & ~tmoM;
    startP = phaseSel;
    prevTuned = tunedPhase;
    n = 0;
    tmoSeen = 1'b0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    forever begin
      if (tmoLoad) begin
        tmoSeen = 1'b1;
        chk(tmoValue == 24'hFFFFFF, "R3 tmoValue", tmoValue, 24'hFFFFFF);
      end
      if (done) break;
      if (xferReq) begin
        chk(int'(phaseSel) == (startP + n + 1) % 8, "R2 transfer phase", phaseSel, (startP + n + 1) % 8);
        chk(tmoSeen, "R3 load before transfer", tmoSeen, 1);
        tmoSeen = 1'b0;
        lat = (int'(passM) + n) % 3;
        repeat (lat) @(negedge clk);
        xferAck = 1'b1;
        xferPass = passM[phaseSel];
        xferTimeout = tmoM[phaseSel];
        if (midStart && n == 3) startReq = 1'b1;  // R1: must be ignored
        n++;
        @(negedge clk);
        xferAck = 1'b0;
        xferPass = 1'b0;
        xferTimeout = 1'b0;
        startReq = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    exp = refPick(eff);
    chk(n == 8, "R4 transfer count", n, 8);
    if (midStart) chk(n == 8, "R1 mid-sweep start ignored", n, 8);
    chk(candMask == eff, "R5 candidate mask", candMask, eff);
    if (exp < 0) begin
      chk(error == 1'b1, "R9 error flag", error, 1);
      chk(int'(phaseSel) == startP, "R9 phase kept", phaseSel, startP);
      chk(int'(tunedPhase) == prevTuned, "R9 tuned kept", tunedPhase, prevTuned);
    end else begin
      chk(error == 1'b0, "R10 error clear", error, 0);
      chk(int'(phaseSel) == exp, "R6/R7/R8 picked phase", phaseSel, exp);
      chk(int'(tunedPhase) == exp, "R10 tuned phase", tunedPhase, exp);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(phaseSel == 3'd0, "R11 reset phase", phaseSel, 0);
    chk(tunedPhase == 3'd0, "R11 reset tuned", tunedPhase, 0);
    chk(done == 1'b0 && error == 1'b0, "R11 reset flags", {done, error}, 0);
    chk(xferReq == 1'b0, "R11 reset request", xferReq, 0);
    for (int m = 0; m < 256; m++) sweep(8'(m), 8'h00, m % 37 == 5);
    for (int k = 0; k < 16; k++) sweep(8'hFF, 8'(k * 23 + 1), 1'b0);
    sweep(8'h00, 8'h00, 1'b1);
    sweep(8'hFF, 8'hFF, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule